// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block collects the interrupt conditions of a synchronous serial port into one place. Four sources feed it: a receive overrun, a receive idle timeout, a receive queue at least half full and a transmit queue at most half full. The block keeps a raw status word that always shows the sources, whatever the mask holds. It also keeps a mask word written by software, a masked status word, and one registered interrupt line.

The surrounding port supplies the queue occupancy counts, a strobe for each receive-queue write and read, and one tick per serial bit period. Overrun and timeout are latched events, and software clears them through a clear register. The two queue-level sources follow the occupancy counts directly, so no write can clear them. A small write port selects the mask register or the clear register, and the current mask is always visible on an output.

Top module: `ssp_irq_status`

## Requirements
- R1: Status bit positions are fixed: bit 0 overrun, bit 1 receive timeout, bit 2 receive half full, bit 3 transmit half empty, in the raw word, the mask word and the masked word alike.
- R2: A receive write (`rx_push`) while `rx_level` equals DEPTH sets the overrun bit on the next clock, and the bit stays set until it is cleared.
- R3: While `rx_level` is nonzero and no receive write or read occurs, each `bit_tick` advances an idle count. The timeout bit is set on the clock of the TMO_BITS-th such tick. Any receive write, any receive read or an empty receive queue restarts the count.
- R4: Bit 2 is 1 exactly when `rx_level` >= DEPTH/2, and bit 3 is 1 exactly when `tx_level` <= DEPTH/2. Both are live combinational levels with no latching.
- R5: The raw status word does not depend on the mask register.
- R6: The masked status word equals the raw word ANDed bitwise with the mask.
- R7: A write with `wr_sel`=1 clears each of bits 0 and 1 whose `wr_data` bit is 1. The `wr_data` bits 2 and 3 of such a write have no effect.
- R8: When a set event and a clear of the same bit fall in the same cycle, the bit ends set.
- R9: `irq` equals, one clock later, the OR of the four masked bits.
- R10: A write with `wr_sel`=0 loads `wr_data` into the mask, visible on `mask_q` the next cycle. Writing zero blocks `irq`, and writing the old value back restores it with the latched raw bits intact.
- R11: After reset the overrun and timeout bits, the mask and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per serial bit period |
| rx_push | input | 1 | A frame is written into the receive queue |
| rx_pop | input | 1 | A word is read from the receive queue |
| rx_level | input | $clog2(DEPTH+1) | Receive queue occupancy |
| tx_level | input | $clog2(DEPTH+1) | Transmit queue occupancy |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mask register, 1 selects the clear register |
| wr_data | input | 4 | Write data |
| mask_q | output | 4 | Current mask |
| raw_stat | output | 4 | Raw status |
| masked_stat | output | 4 | Masked status |
| irq | output | 1 | Combined interrupt request |

## Verification
An overrun or a timeout event can fall in the same cycle as a clear write to that bit. The bench provokes this by driving a receive write into a full queue while it writes the clear register with bit 0 set. It also lines up a final idle tick with a clear of bit 1. In both cases the reference model and an explicit check expect the bit to stay set. A second overlap is a mask write in the same cycle as a new event. There the raw bit must appear at once, while `irq` follows the new mask one clock later.

// File: rtl/ssp_irq_status.sv
module ssp_irq_status #(
  parameter int DEPTH    = 8,
  parameter int TMO_BITS = 32,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TMO_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [3:0]    wr_data,
  output logic [3:0]    mask_q,
  output logic [3:0]    raw_stat,
  output logic [3:0]    masked_stat,
  output logic          irq
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [TW-1:0] LAST = TW'(TMO_BITS - 1);
  localparam logic [TW-1:0] SAT  = TW'(TMO_BITS);

  logic          ovr_q, tmo_q;
  logic [TW-1:0] idle_cnt;

  wire clr_wr   = wr_en & wr_sel;
  wire idle_rst = rx_push | rx_pop | (rx_level == '0);
  wire ovr_evt  = rx_push & (rx_level == FULL);
  wire tmo_evt  = bit_tick & ~idle_rst & (idle_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (idle_rst) idle_cnt <= '0;
    else if (bit_tick && idle_cnt != SAT) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      ovr_q <= ovr_evt | (ovr_q & ~(clr_wr & wr_data[0]));
      tmo_q <= tmo_evt | (tmo_q & ~(clr_wr & wr_data[1]));
      if (wr_en && !wr_sel) mask_q <= wr_data;
      irq <= |masked_stat;
    end
  end

  assign raw_stat    = {tx_level <= HALF, rx_level >= HALF, tmo_q, ovr_q};
  assign masked_stat = raw_stat & mask_q;

  p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_level == FULL |=> raw_stat[0]);
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stat[0] && !(wr_en && wr_sel && wr_data[0]) |=> raw_stat[0]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_level == FULL && wr_en && wr_sel && wr_data[0] |=> raw_stat[0]);
  p_no_tmo_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == '0 |=> !$rose(raw_stat[1]));
  p_mask_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |=> !irq);
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> mask_q == $past(wr_data));
endmodule

// File: tb/ssp_irq_status_bench.sv
module ssp_irq_status_bench;
  localparam int DEPTH = 8;
  localparam int TMO = 6;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, rx_push = 0, rx_pop = 0, wr_en = 0, wr_sel = 0;
  logic [LW-1:0] rx_level = 0, tx_level = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] mask_q, raw_stat, masked_stat;
  logic irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  int m_ovr, m_tmo, m_mask, m_irq, m_idle;

  always #4 clk = ~clk;

  ssp_irq_status #(.DEPTH(DEPTH), .TMO_BITS(TMO)) u_ssp_irq_status (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_push(rx_push),
    .rx_pop(rx_pop), .rx_level(rx_level), .tx_level(tx_level),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mask_q(mask_q), .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq));

  function automatic int exp_raw();
    int r;
    r = (m_ovr ? 1 : 0) | (m_tmo ? 2 : 0);
    if (int'(rx_level) >= DEPTH / 2) r |= 4;
    if (int'(tx_level) <= DEPTH / 2) r |= 8;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovr = 0; m_tmo = 0; m_mask = 0; m_irq = 0; m_idle = 0;
    end else begin
      bit tmo_fire, ovr_fire;
      m_irq = ((exp_raw() & m_mask) != 0) ? 1 : 0;
      ovr_fire = rx_push && int'(rx_level) == DEPTH;
      tmo_fire = 0;
      if (rx_push || rx_pop || rx_level == 0) m_idle = 0;
      else if (bit_tick) begin
        if (m_idle == TMO - 1) tmo_fire = 1;
        if (m_idle < TMO) m_idle++;
      end
      if (wr_en && wr_sel && wr_data[0]) m_ovr = 0;
      if (wr_en && wr_sel && wr_data[1]) m_tmo = 0;
      if (ovr_fire) m_ovr = 1;
      if (tmo_fire) m_tmo = 1;
      if (wr_en && !wr_sel) m_mask = int'(wr_data);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #3;
    if (rst_n && !done) begin
      int er;
      er = exp_raw();
      chk("R2 overrun bit", int'(raw_stat[0]), er & 1);
      chk("R3 timeout bit", int'(raw_stat[1]), (er >> 1) & 1);
      chk("R4 level bits", int'(raw_stat[3:2]), (er >> 2) & 3);
      chk("R6 masked", int'(masked_stat), er & m_mask);
      chk("R9 irq", int'(irq), m_irq);
      chk("R10 mask", int'(mask_q), m_mask);
    end
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input bit push, input bit pop, input int rxl, input int txl,
                       input bit tick, input bit we, input bit sel, input int wd);
    @(negedge clk);
    rx_push = push; rx_pop = pop; rx_level = LW'(rxl); tx_level = LW'(txl);
    bit_tick = tick; wr_en = we; wr_sel = sel; wr_data = 4'(wd);
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R11 reset raw sticky", int'(raw_stat[1:0]), 0);
    chk("R11 reset mask", int'(mask_q), 0);
    chk("R11 reset irq", int'(irq), 0);
    rst_n = 1;

    drive(0, 0, 2, 6, 0, 0, 0, 0);
    settle();
    chk("R1 idle raw word", int'(raw_stat), 0);
    drive(0, 0, 2, 6, 0, 1, 0, 'hF);
    drive(1, 0, 8, 6, 0, 0, 0, 0);
    settle();
    chk("R1 R2 overrun at bit0 with rx full bit2", int'(raw_stat), 'h5);
    drive(0, 0, 8, 6, 0, 0, 0, 0);
    settle();
    chk("R9 irq from overrun", int'(irq), 1);

    drive(0, 0, 2, 6, 0, 1, 0, 0);
    settle(); settle();
    chk("R10 irq blocked", int'(irq), 0);
    chk("R5 raw kept under zero mask", int'(raw_stat), 'h1);
    chk("R6 masked zero", int'(masked_stat), 0);
    drive(0, 0, 2, 6, 0, 1, 0, 'hF);
    settle(); settle();
    chk("R10 irq restored", int'(irq), 1);

    drive(0, 0, 5, 3, 0, 1, 1, 'hC);
    settle();
    chk("R7 clear of level bits ignored", int'(raw_stat), 'hD);
    drive(0, 0, 5, 3, 0, 1, 1, 'h1);
    settle();
    chk("R7 overrun cleared", int'(raw_stat), 'hC);

    drive(1, 0, 8, 6, 0, 1, 1, 'h1);
    settle();
    chk("R8 set wins over clear", int'(raw_stat[0]), 1);
    drive(0, 0, 2, 6, 0, 1, 1, 'h1);

    for (int i = 0; i < TMO - 1; i++) drive(0, 0, 3, 6, 1, 0, 0, 0);
    settle();
    chk("R3 not yet timed out", int'(raw_stat[1]), 0);
    drive(0, 0, 3, 6, 1, 1, 1, 'h2);
    settle();
    chk("R3 R8 timeout set despite clear", int'(raw_stat[1]), 1);
    drive(0, 0, 3, 6, 0, 1, 1, 'h2);
    settle();
    chk("R7 timeout cleared", int'(raw_stat[1]), 0);

    for (int i = 0; i < TMO - 2; i++) drive(0, 0, 3, 6, 1, 0, 0, 0);
    drive(0, 1, 3, 6, 1, 0, 0, 0);
    for (int i = 0; i < TMO - 1; i++) drive(0, 0, 2, 6, 1, 0, 0, 0);
    settle();
    chk("R3 read restarts count", int'(raw_stat[1]), 0);
    for (int i = 0; i < 2 * TMO; i++) drive(0, 0, 0, 6, 1, 0, 0, 0);
    settle();
    chk("R3 empty queue no timeout", int'(raw_stat[1]), 0);

    for (int l = 0; l <= DEPTH; l++) begin
      drive(0, 0, l, DEPTH - l, 0, 0, 0, 0);
      settle();
      chk("R4 rx half full", int'(raw_stat[2]), (l >= DEPTH / 2) ? 1 : 0);
      chk("R4 tx half empty", int'(raw_stat[3]), (DEPTH - l <= DEPTH / 2) ? 1 : 0);
    end

    drive(0, 0, 2, 6, 0, 1, 0, 'h4);
    drive(1, 0, 8, 6, 0, 1, 0, 'h1);
    settle();
    chk("R9 irq under old mask", int'(irq), 1);
    drive(0, 0, 2, 6, 0, 0, 0, 0);
    settle();
    chk("R9 irq follows new mask", int'(irq), 1);

    repeat (3) drive(0, 0, 2, 6, 0, 0, 0, 0);
    settle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule